// File: doc/BRIEF.md
# Discriminator Test Pattern Generator

This block feeds a zero-suppression stage with synthetic discriminator rows so that its handling of awkward hit layouts can be exercised without a real sensor. Every frame is made of two line words, the first called line A and the second line B, each one bit per column across 960 columns. A selectable scheme decides which of the two lines carries hits and where they sit. The other line in the frame stays empty.

The schemes are as follows. Two edge schemes light the outermost columns. A boundary scheme lights columns on either side of the first two 64-column block borders. Two walking schemes move a lone hit one column further on each frame. A start pulse latches the scheme and a frame limit. The block then emits one line per clock until the limit is reached, keeps a running count of completed frames, and raises a done flag that holds until the next start. A run of 5000 frames fits in the default 16-bit limit.

Top module: `disc_pattern_gen`

## Requirements
- R1: While reset is high and on the cycle after it, line_valid, done and frame_count are 0 and line_word is all-zero.
- R2: After a start pulse with a non-zero limit, line_valid is low on the first cycle after the start edge. From the second cycle onward it is high for 2×limit consecutive cycles. The lines alternate A, B, A, B, starting with A.
- R3: Mode code 0 puts hits on columns 0 and 959 in line A and leaves line B empty. Mode code 1 does the reverse.
- R4: Mode code 2 puts hits on columns 0, 63, 64, 127 and 128 in line A and leaves line B empty.
- R5: Mode code 3 puts a single hit in line A of frame f at column f mod 960, with line B empty. Mode code 4 does the same in line B, with line A empty.
- R6: frame_count is 0 after start and goes up by one in the same cycle that a line B is presented. It never exceeds the latched limit and equals the limit once done is high.
- R7: done rises on the cycle after the last line B, while line_valid is low. It stays high, with line_valid low, until the next start.
- R8: A start with limit 0 emits no line, and done is high on the first cycle after the start edge.
- R9: Mode codes 5 to 7 emit all-zero words on both lines.
- R10: A start pulse during a run abandons that run and begins a new one from frame 0 with the newly presented mode and limit.
- R11: Limits up to 65535 are accepted. A 5000-frame fixed run and a walk past column 959 complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that latches mode and limit and begins a run |
| mode | input | 3 | Pattern scheme code (0 to 7) |
| frame_limit | input | 16 | Number of frames to emit |
| line_word | output | 960 | Current line, bit i is column i |
| line_valid | output | 1 | High for each cycle that carries a line |
| frame_count | output | 16 | Frames completed in this run |
| done | output | 1 | Run finished; held until next start |

## Verification
Properties checked on every cycle cover the following:
- valid and done are never high together;
- done persists until a start;
- the frame counter only holds or steps by one and stays within the latched limit;
- the popcount of each emitted line matches its scheme: a single hit or none for the walks, two or none for the edges, and five or none for the boundary set.

Only the bench's scenarios can show the following:
- which line (A or B) carries the hits;
- the exact column of each hit and the walk's wrap from 959 to 0;
- the timing of the first line and of done;
- what happens on a restart in mid-run.

// File: rtl/disc_pattern_gen.sv
module disc_pattern_gen #(
  parameter int NCOL = 960,
  parameter int BLK  = 64,
  parameter int FW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [FW-1:0]   frame_limit,
  output logic [NCOL-1:0] line_word,
  output logic            line_valid,
  output logic [FW-1:0]   frame_count,
  output logic            done
);
  localparam int IW = $clog2(NCOL);
  localparam logic [2:0] M_EDGE_A = 3'd0, M_EDGE_B = 3'd1, M_BOUND = 3'd2,
                         M_WALK_A = 3'd3, M_WALK_B = 3'd4;
  localparam logic [NCOL-1:0] ONE = NCOL'(1);

  logic [2:0]      mode_q;
  logic [FW-1:0]   lim_q;
  logic [IW-1:0]   widx;
  logic            run, phase;
  logic [NCOL-1:0] edge_v, bound_v, walk_v, nxt;

  assign edge_v  = ONE | (ONE << (NCOL-1));
  assign bound_v = ONE | (ONE << (BLK-1)) | (ONE << BLK) | (ONE << (2*BLK-1)) | (ONE << (2*BLK));
  assign walk_v  = ONE << widx;

  always_comb begin
    case (mode_q)
      M_EDGE_A: nxt = phase ? '0 : edge_v;
      M_EDGE_B: nxt = phase ? edge_v : '0;
      M_BOUND:  nxt = phase ? '0 : bound_v;
      M_WALK_A: nxt = phase ? '0 : walk_v;
      M_WALK_B: nxt = phase ? walk_v : '0;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0; lim_q <= '0; widx <= '0; run <= 1'b0; phase <= 1'b0;
      line_word <= '0; line_valid <= 1'b0; frame_count <= '0; done <= 1'b0;
    end else if (start) begin
      mode_q <= mode; lim_q <= frame_limit; widx <= '0; phase <= 1'b0;
      run <= (frame_limit != '0);
      done <= (frame_limit == '0);
      line_word <= '0; line_valid <= 1'b0; frame_count <= '0;
    end else if (run) begin
      line_valid <= 1'b1;
      line_word  <= nxt;
      phase      <= ~phase;
      if (phase) begin
        frame_count <= frame_count + 1'b1;
        widx <= (widx == IW'(NCOL-1)) ? '0 : widx + 1'b1;
        if (frame_count + 1'b1 == lim_q) run <= 1'b0;
      end
    end else begin
      line_valid <= 1'b0;
      line_word  <= '0;
      if (line_valid) done <= 1'b1;
    end
  end
endmodule

// File: rtl/disc_pattern_gen_chk.sv
module disc_pattern_gen_chk #(
  parameter int NCOL = 960,
  parameter int FW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [2:0]      mode_q,
  input logic [FW-1:0]   lim_q,
  input logic [NCOL-1:0] line_word,
  input logic            line_valid,
  input logic [FW-1:0]   frame_count,
  input logic            done
);
  // R7
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_valid && done));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> (frame_count == $past(frame_count) || frame_count == FW'($past(frame_count) + 1'b1)));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    frame_count <= lim_q);
  // R5
  walk_single_chk: assert property (@(posedge clk) disable iff (rst)
    (line_valid && mode_q >= 3'd3) |-> $onehot0(line_word));
  // R3
  edge_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (line_valid && mode_q <= 3'd1) |-> ($countones(line_word) == 0 || $countones(line_word) == 2));
  // R4
  bound_set_chk: assert property (@(posedge clk) disable iff (rst)
    (line_valid && mode_q == 3'd2) |-> ($countones(line_word) == 0 || $countones(line_word) == 5));
endmodule

bind disc_pattern_gen disc_pattern_gen_chk #(.NCOL(NCOL), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode_q(mode_q), .lim_q(lim_q),
  .line_word(line_word), .line_valid(line_valid), .frame_count(frame_count), .done(done)
);

// File: tb/disc_pattern_gen_bench.sv
module disc_pattern_gen_bench;
  localparam int NCOL = 960;
  localparam int FW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] mode = '0;
  logic [FW-1:0] lim = '0;
  logic [NCOL-1:0] word;
  logic valid, done;
  logic [FW-1:0] fcnt;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  disc_pattern_gen u_disc_pattern_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .frame_limit(lim),
    .line_word(word), .line_valid(valid), .frame_count(fcnt), .done(done)
  );

  function automatic logic [NCOL-1:0] exp_word(input int m, input int f, input int p);
    logic [NCOL-1:0] w = '0;
    case (m)
      0: if (p == 0) begin w[0] = 1'b1; w[NCOL-1] = 1'b1; end
      1: if (p == 1) begin w[0] = 1'b1; w[NCOL-1] = 1'b1; end
      2: if (p == 0) begin w[0] = 1'b1; w[63] = 1'b1; w[64] = 1'b1; w[127] = 1'b1; w[128] = 1'b1; end
      3: if (p == 0) w[f % NCOL] = 1'b1;
      4: if (p == 1) w[f % NCOL] = 1'b1;
      default: ;
    endcase
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic chk_word(input string tag, input logic [NCOL-1:0] expv);
    runs++;
    if (word !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, word, expv);
    end
  endtask

  task automatic run(input int m, input int l);
    @(negedge clk);
    mode = 3'(m); lim = FW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b0, "R2 no line on start cycle", valid, 0);
    chk(fcnt == '0, "R6 count cleared", fcnt, 0);
    if (l == 0) begin
      chk(done == 1'b1, "R8 zero limit done", done, 1);
      @(negedge clk);
      chk(done == 1'b1 && valid == 1'b0, "R8 zero limit no lines", valid, 0);
      return;
    end
    chk(done == 1'b0, "R7 done cleared by start", done, 0);
    for (int f = 0; f < l; f++) begin
      for (int p = 0; p < 2; p++) begin
        @(negedge clk);
        chk(valid == 1'b1, "R2 line valid", valid, 1);
        if (m >= 5) chk_word("R9 empty word", '0);
        else if (m == 2) chk_word("R4 boundary word", exp_word(m, f, p));
        else if (m >= 3) chk_word((f >= NCOL) ? "R11 walk wrap word" : "R5 walk word", exp_word(m, f, p));
        else chk_word("R3 edge word", exp_word(m, f, p));
        chk(fcnt == FW'(f + p), "R6 frame count", fcnt, f + p);
      end
    end
    @(negedge clk);
    chk(done == 1'b1 && valid == 1'b0, "R7 done after last line", done, 1);
    chk(fcnt == FW'(l), "R6 final count", fcnt, l);
    @(negedge clk);
    chk(done == 1'b1 && valid == 1'b0, "R7 done held", done, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(valid == 0 && done == 0 && fcnt == 0 && word == '0, "R1 reset outputs", valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid == 0 && done == 0 && fcnt == 0 && word == '0, "R1 after reset", done, 0);
    run(0, 3); run(1, 3); run(2, 4); run(3, 12); run(4, 12);
    run(5, 2); run(6, 1); run(7, 2); run(2, 0);
    @(negedge clk); mode = 3'd0; lim = FW'(10); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    run(4, 6); // R10 restart in mid-run
    for (int i = 0; i < 30; i++) run(int'($urandom_range(7)), int'($urandom_range(40)));
    run(0, 5000); // R11
    run(4, 500);
    run(3, 963);  // R11 walk wrap
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule